// File: doc/BRIEF.md
# Iterative Integer Multiply and Divide Unit

This block is a sequential arithmetic unit for 32-bit integers. One command holds two operands and a two-bit operation code. The code selects signed multiply, unsigned multiply, signed divide or unsigned divide. The unit works through the operation one bit per cycle. Multiply uses shift-and-add. Divide uses restoring subtraction. The unit then writes the outcome into a pair of result registers called HI and LO. These registers are separate from any general register file. They reach the rest of the core only through two read ports. For a multiply, HI and LO hold the upper and lower halves of the full double-width product. For a divide, HI holds the remainder and LO holds the quotient.

Commands use a simple handshake. The unit accepts `start_i` on any rising edge where `busy_o` is low, so `busy_o` low is the ready condition. The operands and the operation code are captured on that edge only. While `busy_o` is high, the unit gives back-pressure by ignoring any `start_i`. A request made during that time is dropped and is not queued. The unit raises no overflow, divide-by-zero or exception indication. Software must inspect HI itself if it cares.

Top module: `mdu_top`

## Requirements
- R1: Operation code 2'b00 is a signed multiply and 2'b01 is an unsigned multiply. In both cases HI receives bits [2W-1:W] of the 2W-bit product and LO receives bits [W-1:0]. For operands with the top bit set, the signed and unsigned products differ.
- R2: Operation code 2'b11 is an unsigned divide. LO receives the quotient and HI receives the remainder, so that dividend = quotient × divisor + remainder with remainder < divisor.
- R3: Operation code 2'b10 is a signed divide that truncates toward zero. The remainder carries the sign of the dividend. The most negative value divided by -1 wraps to a quotient equal to the most negative value, with remainder 0, and nothing is flagged.
- R4: A divide by zero completes with normal timing and sets HI to the dividend. For an unsigned divide, LO becomes all ones. For a signed divide, LO becomes all ones for a non-negative dividend and 1 for a negative dividend.
- R5: After an accepted start, `busy_o` is high for exactly W+2 cycles: one setup cycle, W iteration cycles and one finish cycle. `done_o` is high for the single cycle right after that, and HI and LO show the new result in that same cycle.
- R6: A `start_i` that arrives while `busy_o` is high is ignored. The running operation keeps its original operands and operation code, and its latency does not change.
- R7: HI and LO change only in a cycle where `done_o` is high. At all other times they hold their last value.
- R8: After reset, `busy_o` and `done_o` are low, and HI and LO read zero.
- R9: A start presented in the cycle where `done_o` is high is accepted. The next operation begins with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command request; accepted when busy_o is low |
| op_i | input | 2 | Operation: bit 1 selects divide, bit 0 selects unsigned |
| opa_i | input | WIDTH | Multiplicand, or dividend |
| opb_i | input | WIDTH | Multiplier, or divisor |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse when HI and LO take a new result |
| hi_o | output | WIDTH | HI read port |
| lo_o | output | WIDTH | LO read port |

## Verification
Some corner cases are hard to reach at full width. These are the most-negative-over-minus-one wrap, division by zero with a negative dividend, and products where the sign correction crosses into the high half. Sampling at random rarely hits them. The bench therefore builds a 5-bit instance and runs every operand pair under all four operation codes. In every run it also pulses `start_i` with corrupted operands partway through the busy window. A second 32-bit instance runs targeted edge values, and a chained pair tests issue in the done cycle.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_STEP = 2'd2,
    ST_FIN  = 2'd3
  } mdu_state_e;
endpackage

// File: rtl/mdu_seq.sv
module mdu_seq import mdu_pkg::*; #(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic accept_o,
  output logic prep_o,
  output logic step_o,
  output logic fin_o
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  mdu_state_e state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_PREP;
        ST_PREP: begin
          state_q <= ST_STEP;
          cnt_q   <= '0;
        end
        ST_STEP: begin
          if (cnt_q == LAST) state_q <= ST_FIN;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign prep_o   = (state_q == ST_PREP);
  assign step_o   = (state_q == ST_STEP);
  assign fin_o    = (state_q == ST_FIN);

  // R5
  step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STEP && cnt_q != LAST) |=> (state_q == ST_STEP && cnt_q == $past(cnt_q) + 1'b1));

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STEP && start_i) |=> (state_q != ST_PREP));
endmodule

// File: rtl/mdu_sign.sv
module mdu_sign #(
  parameter int W = 32
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         is_div_o,
  output logic         neg_main_o,
  output logic         neg_rem_o
);
  logic signed_op, a_neg, b_neg;

  always_comb begin
    signed_op  = ~op_i[0];
    is_div_o   = op_i[1];
    a_neg      = signed_op & a_i[W-1];
    b_neg      = signed_op & b_i[W-1];
    mag_a_o    = a_neg ? (~a_i + 1'b1) : a_i;
    mag_b_o    = b_neg ? (~b_i + 1'b1) : b_i;
    neg_main_o = a_neg ^ b_neg;
    neg_rem_o  = op_i[1] & a_neg;
  end
endmodule

// File: rtl/mdu_core.sv
module mdu_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         prep_i,
  input  logic         step_i,
  input  logic         is_div_i,
  input  logic         neg_main_i,
  input  logic         neg_rem_i,
  input  logic [W-1:0] mag_a_i,
  input  logic [W-1:0] mag_b_i,
  output logic [W-1:0] res_hi_o,
  output logic [W-1:0] res_lo_o
);
  localparam int DW = 2 * W;

  logic [DW-1:0] p_q, p_next, prod;
  logic [W-1:0]  m_q;
  logic [W:0]    add_sum, shifted;
  logic [W+1:0]  diff;

  always_comb begin
    add_sum = {1'b0, p_q[DW-1:W]} + {1'b0, (p_q[0] ? m_q : '0)};
    shifted = {p_q[DW-1:W], p_q[W-1]};
    diff    = {1'b0, shifted} - {2'b00, m_q};
    if (!is_div_i)    p_next = {add_sum, p_q[W-1:1]};
    else if (!diff[W+1]) p_next = {diff[W-1:0], p_q[W-2:0], 1'b1};
    else              p_next = {shifted[W-1:0], p_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
      m_q <= '0;
    end else if (prep_i) begin
      p_q <= {{W{1'b0}}, mag_a_i};
      m_q <= mag_b_i;
    end else if (step_i) begin
      p_q <= p_next;
    end
  end

  always_comb begin
    prod = neg_main_i ? (~p_q + 1'b1) : p_q;
    if (is_div_i) begin
      res_hi_o = neg_rem_i  ? (~p_q[DW-1:W] + 1'b1) : p_q[DW-1:W];
      res_lo_o = neg_main_i ? (~p_q[W-1:0] + 1'b1)  : p_q[W-1:0];
    end else begin
      res_hi_o = prod[DW-1:W];
      res_lo_o = prod[W-1:0];
    end
  end

  // R4
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && is_div_i && m_q == '0) |=> p_q[0]);
endmodule

// File: rtl/mdu_top.sv
module mdu_top import mdu_pkg::*; #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  logic accept, prep, step, fin, busy;
  logic [1:0]       op_q;
  logic [WIDTH-1:0] a_q, b_q, mag_a, mag_b, res_hi, res_lo, hi_q, lo_q;
  logic is_div, neg_main, neg_rem, done_q;

  mdu_seq #(.STEPS(WIDTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy),
    .accept_o(accept), .prep_o(prep), .step_o(step), .fin_o(fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else if (accept) begin
      op_q <= op_i;
      a_q  <= opa_i;
      b_q  <= opb_i;
    end
  end

  mdu_sign #(.W(WIDTH)) u_sign (
    .op_i(op_q), .a_i(a_q), .b_i(b_q), .mag_a_o(mag_a), .mag_b_o(mag_b),
    .is_div_o(is_div), .neg_main_o(neg_main), .neg_rem_o(neg_rem)
  );

  mdu_core #(.W(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .prep_i(prep), .step_i(step), .is_div_i(is_div),
    .neg_main_i(neg_main), .neg_rem_i(neg_rem), .mag_a_i(mag_a), .mag_b_i(mag_b),
    .res_hi_o(res_hi), .res_lo_o(res_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) begin
        hi_q <= res_hi;
        lo_q <= res_lo;
      end
    end
  end

  assign busy_o = busy;
  assign done_o = done_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  // R7
  hilo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(hi_q) && $stable(lo_q)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy && $past(busy)));

  // R6
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> ($stable(a_q) && $stable(b_q) && $stable(op_q)));
endmodule

// File: tb/mdu_top_tb.sv
module mdu_top_tb;
  localparam int SW = 5;
  localparam int WW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;

  logic          s_start = 1'b0;
  logic [1:0]    s_op = '0;
  logic [SW-1:0] s_a = '0, s_b = '0;
  logic          s_busy, s_done;
  logic [SW-1:0] s_hi, s_lo;

  logic          w_start = 1'b0;
  logic [1:0]    w_op = '0;
  logic [WW-1:0] w_a = '0, w_b = '0;
  logic          w_busy, w_done;
  logic [WW-1:0] w_hi, w_lo;

  mdu_top #(.WIDTH(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(s_start), .op_i(s_op), .opa_i(s_a),
    .opb_i(s_b), .busy_o(s_busy), .done_o(s_done), .hi_o(s_hi), .lo_o(s_lo)
  );

  mdu_top #(.WIDTH(WW)) u_wide (
    .clk(clk), .rst_n(rst_n), .start_i(w_start), .op_i(w_op), .opa_i(w_a),
    .opb_i(w_b), .busy_o(w_busy), .done_o(w_done), .hi_o(w_hi), .lo_o(w_lo)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model(input int w, input logic [1:0] op, input logic [31:0] a,
                                input logic [31:0] b, output logic [31:0] hi, output logic [31:0] lo);
    logic [63:0] mask, pr;
    longint sa, sb, q, r;
    mask = (64'd1 << w) - 64'd1;
    sa = a[w-1] ? longint'(a) - (longint'(1) << w) : longint'(a);
    sb = b[w-1] ? longint'(b) - (longint'(1) << w) : longint'(b);
    hi = '0; lo = '0;
    if (!op[1]) begin
      if (op[0]) pr = {32'd0, a} * {32'd0, b};
      else       pr = 64'(sa * sb);
      lo = 32'(pr & mask);
      hi = 32'((pr >> w) & mask);
    end else if (b == 0) begin
      hi = a;
      lo = (!op[0] && sa < 0) ? 32'd1 : 32'(mask);
    end else if (op[0]) begin
      lo = a / b;
      hi = a % b;
    end else begin
      q = sa / sb;
      r = sa % sb;
      lo = 32'(64'(q) & mask);
      hi = 32'(64'(r) & mask);
    end
  endfunction

  function automatic string tag(input logic [1:0] op, input logic [31:0] b);
    if (!op[1]) return "R1";
    if (b == 0) return "R4";
    return op[0] ? "R2" : "R3";
  endfunction

  // Drive a command at the current negedge; returns at the following negedge.
  task automatic s_issue(input logic [1:0] op, input logic [SW-1:0] a, input logic [SW-1:0] b);
    s_start = 1'b1; s_op = op; s_a = a; s_b = b;
    @(negedge clk);
    s_start = 1'b0;
  endtask

  // Counts busy cycles until done; injects an ignored start (R6) in busy cycle 2.
  task automatic s_wait(input logic [1:0] op, input logic [SW-1:0] a, input logic [SW-1:0] b, output int cyc);
    int guard;
    cyc = 0; guard = 0;
    while (!s_done && guard < 100) begin
      if (s_busy) cyc++;
      if (cyc == 2) begin
        s_start = 1'b1; s_op = ~op; s_a = ~a; s_b = b + 1'b1;
      end else begin
        s_start = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    s_start = 1'b0;
    if (guard >= 100) check(1'b0, "R5 timeout", 64'(guard), 64'(SW + 2));
  endtask

  task automatic s_result(input logic [1:0] op, input logic [SW-1:0] a, input logic [SW-1:0] b, input int cyc);
    logic [31:0] eh, el;
    model(SW, op, 32'(a), 32'(b), eh, el);
    // R5 busy length and done alignment, R6 latency unchanged by injected start
    check(cyc == SW + 2 && s_done && !s_busy, "R5/R6 timing", 64'(cyc), 64'(SW + 2));
    check(s_hi == SW'(eh), tag(op, 32'(b)), 64'(s_hi), 64'(eh));
    check(s_lo == SW'(el), tag(op, 32'(b)), 64'(s_lo), 64'(el));
  endtask

  task automatic w_run(input logic [1:0] op, input logic [WW-1:0] a, input logic [WW-1:0] b);
    int cyc, guard;
    logic [31:0] eh, el;
    @(negedge clk);
    w_start = 1'b1; w_op = op; w_a = a; w_b = b;
    @(negedge clk);
    w_start = 1'b0;
    cyc = 0; guard = 0;
    while (!w_done && guard < 200) begin
      if (w_busy) cyc++;
      @(negedge clk);
      guard++;
    end
    model(WW, op, a, b, eh, el);
    check(cyc == WW + 2 && w_done, "R5 wide timing", 64'(cyc), 64'(WW + 2));
    check(w_hi == eh, tag(op, b), 64'(w_hi), 64'(eh));
    check(w_lo == el, tag(op, b), 64'(w_lo), 64'(el));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic [SW-1:0] hsave, lsave;
    logic [31:0] eh, el;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(!s_busy && !s_done && s_hi == '0 && s_lo == '0, "R8",
          {s_busy, s_done, 27'd0, s_hi, 27'd0, s_lo}, 64'd0);
    check(!w_busy && w_hi == '0 && w_lo == '0, "R8 wide", {w_hi, w_lo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!s_busy && !s_done, "R8 after release", {62'd0, s_busy, s_done}, 64'd0);

    // Exhaustive sweep of the narrow instance
    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < (1 << SW); a++) begin
        for (int b = 0; b < (1 << SW); b++) begin
          s_issue(2'(op), SW'(a), SW'(b));
          s_wait(2'(op), SW'(a), SW'(b), cyc);
          s_result(2'(op), SW'(a), SW'(b), cyc);
          hsave = s_hi; lsave = s_lo;
          @(negedge clk);
          // R7 registers hold once done has dropped
          check(!s_done && s_hi == hsave && s_lo == lsave, "R7 hold",
                {27'd0, s_hi, 27'd0, s_lo}, {27'd0, hsave, 27'd0, lsave});
        end
      end
    end

    // R9 issue in the done cycle
    s_issue(2'b00, 5'h13, 5'h07);
    s_wait(2'b00, 5'h13, 5'h07, cyc);
    s_result(2'b00, 5'h13, 5'h07, cyc);
    s_start = 1'b1; s_op = 2'b11; s_a = 5'h1D; s_b = 5'h04;
    @(negedge clk);
    s_start = 1'b0;
    check(s_busy, "R9 accepted in done cycle", {63'd0, s_busy}, 64'd1);
    s_wait(2'b11, 5'h1D, 5'h04, cyc);
    model(SW, 2'b11, 32'h1D, 32'h04, eh, el);
    check(cyc == SW + 2 && s_hi == SW'(eh) && s_lo == SW'(el), "R9 chained result",
          {27'd0, s_hi, 27'd0, s_lo}, {27'd0, eh[SW-1:0], 27'd0, el[SW-1:0]});

    // Full-width edge values
    w_run(2'b00, 32'hFFFF_FFFD, 32'd7);
    w_run(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    w_run(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    w_run(2'b00, 32'h8000_0000, 32'h8000_0000);
    w_run(2'b10, 32'hFFFF_FFF9, 32'd2);
    w_run(2'b10, 32'd7, 32'hFFFF_FFFE);
    w_run(2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
    w_run(2'b11, 32'hFFFF_FFFF, 32'h10);
    w_run(2'b11, 32'h1234_5678, 32'd0);
    w_run(2'b10, 32'hFFFF_FFFB, 32'd0);
    w_run(2'b10, 32'd9, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule